// File: doc/BRIEF.md
# Request Port Blocking and Retry Guard

This block sits in front of the request port that faces the processor side of a cache. Several independent conditions inside the cache may need to stop new requests, for example a full miss buffer or a full write buffer. Each condition owns one bit of a cause vector. The bit is raised and lowered with its own set and clear strobes. The port refuses requests while any bit is raised.

A requester that was turned away is owed a retry. The block remembers that debt. After the last cause drops, it waits one cycle and then issues a single one-cycle retry pulse. Cause bits may be raised again during that waiting cycle. If that happens, the pending pulse is withdrawn, and the debt carries over to the next full release.

An accepted request goes to the cache core in the same cycle, through a valid strobe and an address. A free-running counter records how many cycles the port has spent blocked.

Top module: `reqport_guard`

## Requirements
- R1: After reset the cause vector reads zero, `reqReady` is high, `retryPulse` is low and `blockedCycles` is zero.
- R2: On each clock edge, cause bit i becomes 1 if `causeSet[i]` is high, becomes 0 if only `causeClr[i]` is high, and otherwise keeps its value. When both strobes are high in the same cycle, the bit is set. Other bits are unaffected.
- R3: `reqReady` is low in every cycle where the cause vector is nonzero or a retry is owed. It is high otherwise.
- R4: In a cycle where `reqValid` and `reqReady` are both high, `coreValid` is high in that same cycle and `coreAddr` equals `reqAddr`. In any other cycle, `coreValid` is low.
- R5: A request presented while `reqReady` is low is refused and creates an owed retry. While the retry is owed, `reqReady` stays low even after the causes clear.
- R6: Suppose cycle N is the first cycle in which the cause vector reads zero while a retry is owed, and no cause is set during cycle N. Then `retryPulse` is high in cycle N+1 only.
- R7: The retry pulse settles the debt. In the pulse cycle `reqReady` is high unless a cause is active, and no further pulse follows without a new refusal.
- R8: If any cause is set during cycle N, the pulse for N+1 is cancelled and the retry stays owed. The pulse then comes one cycle after the next full release.
- R9: Blocking and unblocking with no refused request produces no retry pulse.
- R10: `blockedCycles` rises by one, modulo 2^CNT_W, after every cycle in which the cause vector is nonzero. It holds its value otherwise.
- R11: `retryPulse` is never high while the cause vector is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Requester presents a request |
| reqAddr | input | ADDR_W | Request address |
| reqReady | output | 1 | Port accepts a request this cycle |
| coreValid | output | 1 | Accepted request forwarded to the cache core |
| coreAddr | output | ADDR_W | Address forwarded to the cache core |
| causeSet | input | NUM_CAUSES | Per-cause raise strobes |
| causeClr | input | NUM_CAUSES | Per-cause lower strobes |
| blockCauses | output | NUM_CAUSES | Current cause vector |
| retryPulse | output | 1 | One-cycle retry indication |
| blockedCycles | output | CNT_W | Count of blocked cycles, wrapping |

## Verification
Two events can land in the same cycle.

The first pair is the release of the last cause and a fresh refusal. A request is presented in the very cycle the final clear strobe is driven. The bench then expects a pulse one cycle after the vector first reads zero, even though no retry was owed before that cycle.

The second pair is a scheduled retry and a new set strobe. A cause is raised in the waiting cycle. The bench then expects no pulse, `reqReady` held low, and a pulse one cycle after a later release.

A cycle-level model built from the requirements judges both cases. The bench also sweeps every set/clear pattern over three causes, with and without a request.

// File: rtl/portguard_pkg.sv
package portguard_pkg;
  // Strobes from the control module to the datapath
  typedef struct packed {
    logic accept;   // request forwarded to the core this cycle
    logic refuse;   // request turned away this cycle
  } portStrobe_t;
endpackage

// File: rtl/portguard_dp.sv
module portguard_dp
  import portguard_pkg::*;
#(
  parameter int NUM_CAUSES = 4,
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_CAUSES-1:0] causeSet,
  input  logic [NUM_CAUSES-1:0] causeClr,
  input  logic                  reqValid,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  portStrobe_t           strobe,
  output logic [NUM_CAUSES-1:0] causeVec,
  output logic                  anyBlocked,
  output logic                  anyBlockedNext,
  output logic                  coreValid,
  output logic [ADDR_W-1:0]     coreAddr,
  output logic [CNT_W-1:0]      blockedCycles
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [NUM_CAUSES-1:0] causeNext;

  // One register per cause; a set strobe dominates a clear strobe
  for (genvar i = 0; i < NUM_CAUSES; i++) begin : g_cause
    always_comb begin
      if (causeSet[i])      causeNext[i] = 1'b1;
      else if (causeClr[i]) causeNext[i] = 1'b0;
      else                  causeNext[i] = causeVec[i];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) causeVec[i] <= 1'b0;
      else       causeVec[i] <= causeNext[i];
    end

    p_set_wins_r2: assert property (@(posedge clk) disable iff (!rstN)
      causeSet[i] |=> causeVec[i]);
    p_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
      (causeClr[i] && !causeSet[i]) |=> !causeVec[i]);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
      (!causeClr[i] && !causeSet[i]) |=> $stable(causeVec[i]));
  end

  assign anyBlocked     = |causeVec;
  assign anyBlockedNext = |causeNext;

  // Forward accepted requests to the cache core in the same cycle
  assign coreValid = strobe.accept;
  assign coreAddr  = reqAddr;

  always_comb begin
    if (rstN) begin
      a_fwd_only_valid_r4: assert (!coreValid || reqValid);
      a_refuse_blocks_r4:  assert (!(strobe.refuse && coreValid));
    end
  end

  // Blocked-cycle counter, wrapping
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           blockedCycles <= '0;
    else if (anyBlocked) blockedCycles <= blockedCycles + CNT_ONE;
  end

  p_count_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    anyBlocked |=> (blockedCycles == $past(blockedCycles) + CNT_ONE));
  p_count_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !anyBlocked |=> $stable(blockedCycles));
endmodule

// File: rtl/portguard_ctrl.sv
module portguard_ctrl
  import portguard_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        anyBlocked,
  input  logic        anyBlockedNext,
  output portStrobe_t strobe,
  output logic        reqReady,
  output logic        retryPulse
);
  logic owedQ;     // a refused requester is owed a retry
  logic pendingQ;  // release seen, pulse scheduled for next edge
  logic pulseQ;
  logic owedNow;
  logic schedule;
  logic fire;

  assign reqReady = !anyBlocked && !owedQ;

  always_comb begin
    strobe.accept = reqValid && reqReady;
    strobe.refuse = reqValid && !reqReady;
  end

  assign owedNow  = owedQ || strobe.refuse;
  // Last cause drops at this edge with a debt outstanding
  assign schedule = anyBlocked && !anyBlockedNext && owedNow;
  // The scheduled pulse survives only if no cause comes back
  assign fire     = pendingQ && !anyBlockedNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      owedQ    <= 1'b0;
      pendingQ <= 1'b0;
      pulseQ   <= 1'b0;
    end else begin
      owedQ    <= fire ? 1'b0 : owedNow;
      pendingQ <= schedule;
      pulseQ   <= fire;
    end
  end

  assign retryPulse = pulseQ;

  p_blocked_not_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    anyBlocked |-> !reqReady);
  p_refuse_owes_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (!reqReady || retryPulse));
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    retryPulse |=> !retryPulse);
  p_pulse_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (retryPulse && !anyBlocked) |-> reqReady);
  p_cancel_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ && anyBlockedNext) |=> (!retryPulse && !reqReady));
  p_owed_before_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    retryPulse |-> $past(owedQ));
  p_pulse_unblocked_r11: assert property (@(posedge clk) disable iff (!rstN)
    retryPulse |-> !anyBlocked);
endmodule

// File: rtl/reqport_guard.sv
module reqport_guard
  import portguard_pkg::*;
#(
  parameter int NUM_CAUSES = 4,
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [ADDR_W-1:0]     reqAddr,
  output logic                  reqReady,
  output logic                  coreValid,
  output logic [ADDR_W-1:0]     coreAddr,
  input  logic [NUM_CAUSES-1:0] causeSet,
  input  logic [NUM_CAUSES-1:0] causeClr,
  output logic [NUM_CAUSES-1:0] blockCauses,
  output logic                  retryPulse,
  output logic [CNT_W-1:0]      blockedCycles
);
  portStrobe_t strobe;
  logic        anyBlocked;
  logic        anyBlockedNext;

  portguard_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .reqValid       (reqValid),
    .anyBlocked     (anyBlocked),
    .anyBlockedNext (anyBlockedNext),
    .strobe         (strobe),
    .reqReady       (reqReady),
    .retryPulse     (retryPulse)
  );

  portguard_dp #(
    .NUM_CAUSES (NUM_CAUSES),
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .causeSet       (causeSet),
    .causeClr       (causeClr),
    .reqValid       (reqValid),
    .reqAddr        (reqAddr),
    .strobe         (strobe),
    .causeVec       (blockCauses),
    .anyBlocked     (anyBlocked),
    .anyBlockedNext (anyBlockedNext),
    .coreValid      (coreValid),
    .coreAddr       (coreAddr),
    .blockedCycles  (blockedCycles)
  );
endmodule

// File: tb/sim_reqport_guard.sv
module sim_reqport_guard;
  localparam int NC = 3;
  localparam int AW = 8;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic          reqReady;
  logic          coreValid;
  logic [AW-1:0] coreAddr;
  logic [NC-1:0] causeSet = '0;
  logic [NC-1:0] causeClr = '0;
  logic [NC-1:0] blockCauses;
  logic          retryPulse;
  logic [CW-1:0] blockedCycles;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Requirement model state
  logic [NC-1:0] mCauses = '0;
  logic          mOwed = 1'b0;
  logic          mPending = 1'b0;
  logic          mPulse = 1'b0;
  logic [CW-1:0] mCnt = '0;

  always #2 clk = ~clk;  // 250 MHz

  reqport_guard #(.NUM_CAUSES(NC), .ADDR_W(AW), .CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .coreValid(coreValid), .coreAddr(coreAddr),
    .causeSet(causeSet), .causeClr(causeClr), .blockCauses(blockCauses),
    .retryPulse(retryPulse), .blockedCycles(blockedCycles)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // Drive one cycle, compare with the model, then advance the model
  task automatic cycle(input logic [NC-1:0] s, input logic [NC-1:0] c,
                       input logic v, input logic [AW-1:0] a);
    logic ready, refuse, blocked, sched, nPulse;
    logic [NC-1:0] nCauses;
    causeSet = s; causeClr = c; reqValid = v; reqAddr = a;
    #1;
    blocked = (mCauses != 0);
    ready   = !blocked && !mOwed;
    refuse  = v && !ready;
    check("R2 causes", blockCauses, mCauses);
    check("R3 ready", reqReady, ready);
    check("R4 coreValid", coreValid, v && ready);
    if (v && ready) check("R4 coreAddr", coreAddr, a);
    check("R6 pulse", retryPulse, mPulse);
    check("R10 counter", blockedCycles, mCnt);
    @(posedge clk);
    nCauses  = (mCauses & ~c) | s;
    sched    = blocked && (nCauses == 0) && (mOwed || refuse);
    nPulse   = mPending && (nCauses == 0);
    mOwed    = nPulse ? 1'b0 : (mOwed || refuse);
    mPending = sched;
    mPulse   = nPulse;
    mCnt     = mCnt + (blocked ? 1 : 0);
    mCauses  = nCauses;
    #1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    check("R1 causes", blockCauses, 0);
    check("R1 ready", reqReady, 1);
    check("R1 pulse", retryPulse, 0);
    check("R1 counter", blockedCycles, 0);

    // R4 pass-through while idle
    cycle(0, 0, 1, 8'hA5);

    // R5/R6/R7: refused during the final clear
    cycle(3'b001, 0, 0, 0);
    cycle(0, 3'b001, 1, 8'h11);
    check("R5 owed after release", reqReady, 0);
    check("R5 causes empty", blockCauses, 0);
    cycle(0, 0, 0, 0);
    check("R6 pulse fires", retryPulse, 1);
    check("R7 ready in pulse", reqReady, 1);
    cycle(0, 0, 0, 0);
    check("R6 single pulse", retryPulse, 0);
    cycle(0, 0, 0, 0);
    check("R7 no repeat", retryPulse, 0);

    // R8: cause raised in the waiting cycle cancels the pulse
    cycle(3'b010, 0, 0, 0);
    cycle(0, 3'b010, 1, 8'h22);
    cycle(3'b100, 0, 0, 0);
    check("R8 cancelled", retryPulse, 0);
    check("R8 still blocked", reqReady, 0);
    cycle(0, 3'b100, 0, 0);
    check("R8 debt kept", reqReady, 0);
    check("R8 no pulse yet", retryPulse, 0);
    cycle(0, 0, 0, 0);
    check("R8 later pulse", retryPulse, 1);

    // R9: block and release without refusal
    cycle(3'b011, 0, 0, 0);
    cycle(0, 3'b011, 0, 0);
    cycle(0, 0, 0, 0);
    check("R9 no pulse", retryPulse, 0);
    cycle(0, 0, 0, 0);
    check("R9 no pulse late", retryPulse, 0);

    // R2: set and clear in one cycle resolves to set
    cycle(3'b001, 3'b001, 0, 0);
    check("R2 set wins", blockCauses, 1);
    cycle(0, 3'b111, 0, 0);
    cycle(0, 0, 0, 0);

    // R10: hold blocked long enough to wrap the counter
    for (int k = 0; k < 40; k++) cycle(3'b100, 0, 0, 0);
    cycle(0, 3'b111, 0, 0);
    cycle(0, 0, 0, 0);
    cycle(0, 0, 0, 0);

    // Sweep of every set/clear pattern with and without requests;
    // R11 pulse never with causes held by the model compare
    for (int r = 0; r < 2; r++)
      for (int s = 0; s < 8; s++)
        for (int c = 0; c < 8; c++)
          for (int v = 0; v < 2; v++) begin
            cycle(3'(s), 3'(c), 1'(v), 8'(s * 16 + c + r));
            if (retryPulse) check("R11 pulse unblocked", blockCauses, 0);
            if (((s + c + r) % 5) == 0) begin
              cycle(0, 3'b111, 1'(v), 8'h3C);
              cycle(0, 0, 0, 0);
              cycle(0, 0, 1, 8'h5A);
            end
          end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule